// File: doc/BRIEF.md
# I2C Register-Pointer Target

This block is the two-wire serial target that sits in front of the register file of a multichannel converter. It watches already-synchronised SCL and SDA samples on the system clock, detects START and STOP conditions, matches its 7-bit address, and acknowledges bytes. The target pulls a line low through two drive-low outputs: one for SDA and one for SCL.

In a write transfer, the first byte after the address loads an 8-bit pointer. The low nibble of the pointer selects one of sixteen registers. The high nibble is a conversion command, which is issued as a one-cycle pulse. Data bytes that follow are assembled into 8-bit or 16-bit register writes. The width depends on the selected index. Once a register has been written in full, the next byte is taken as a new pointer.

In a read transfer, the pointed register is fetched and shifted out, high byte first. The fetch repeats for as long as the controller keeps acknowledging. If a conversion is still running when a read is addressed, the target holds SCL low until the conversion finishes.

Top module: `cvt_i2c_target`

## Requirements
- R1: The device address is 010 followed by a 4-bit pattern chosen by `addr_sel`: 0 selects `LOW_PAT` (default 4'h1), 1 selects `HIGH_PAT` (default 4'h2), 2 selects `FLOAT_PAT` (default 4'h3), and 3 matches nothing. An address byte (7-bit address, then a R/W bit, 1 = read) is acknowledged only on a match. The target stays silent on SDA until the next START.
- R2: After reset, `sda_low`, `scl_low` and all strobes are 0, and the pointer is 0, so `reg_rd_idx` = 0.
- R3: The first byte of every write transfer loads the pointer, and `reg_rd_idx` follows pointer bits [3:0]. A write that carries only the pointer byte produces no register write strobe.
- R4: Loading a pointer whose bits [7:4] are non-zero gives one `cmd_pulse`, with `cmd_code` equal to those bits. Bits [7:4] equal to zero give no pulse.
- R5: Indices 1 (alarm status) and 3 (cycle timer) take one data byte, placed in `reg_wr_data[7:0]` with the upper byte zero. All other indices take two bytes, most significant byte first. One `reg_wr` pulse carries the index and the assembled value after the final byte.
- R6: After a register has been fully written, the next byte in the same transfer is a new pointer. One transfer can therefore update several registers.
- R7: Each read byte comes from the pointed register. For a 2-byte register the order is upper byte, lower byte, then the upper byte again, and so on. For a 1-byte register, bits [7:0] are returned every time. A `reg_rd` pulse marks each fetch of a new word.
- R8: Data written to index 0 (the read-only result) is acknowledged, and no strobe is produced.
- R9: Writing 8'hFF to index 1 produces `alarm_clr` instead of `reg_wr`. Any other value is written normally.
- R10: A read address that is acknowledged while `conv_busy` = 1 holds `scl_low` from the end of the acknowledge slot until `conv_busy` falls. The first data bit follows after that.
- R11: A STOP returns the block to idle and releases both lines. A half-written 16-bit register is discarded. A repeated START begins a new address phase.
- R12: A NACK from the controller after a read byte ends the transfer. The target then leaves SDA released until the next START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Synchronised SCL sample |
| sda_i | input | 1 | Synchronised SDA sample |
| addr_sel | input | 2 | Address-select level (0 low, 1 high, 2 floating) |
| conv_busy | input | 1 | Commanded conversion in progress |
| reg_rd_data | input | 16 | Contents of the register at `reg_rd_idx` |
| sda_low | output | 1 | Pull SDA low |
| scl_low | output | 1 | Pull SCL low (clock stretch) |
| reg_rd_idx | output | 4 | Index currently selected by the pointer |
| reg_rd | output | 1 | Pulse: word fetched for a read |
| reg_wr | output | 1 | Pulse: register write |
| reg_wr_idx | output | 4 | Index being written |
| reg_wr_data | output | 16 | Value being written |
| alarm_clr | output | 1 | Pulse: clear the alarm status register |
| cmd_pulse | output | 1 | Pulse: conversion command issued |
| cmd_code | output | 4 | Command nibble issued with `cmd_pulse` |

## Verification
The hardest case to reach is the clock stretch. The read address has to be acknowledged while a conversion is flagged busy, and the controller model must then wait on the real SCL line instead of its own drive. To reach it, the bench raises `conv_busy` before addressing a read. It watches the hold persist across many cycles, drops the busy flag, and confirms that the word still arrives intact. Repeated START after a pointer write, STOP in the middle of a 16-bit write, and clocking on past a NACK are each driven as dedicated bus sequences.

// File: rtl/cvt_i2c_pkg.sv
package cvt_i2c_pkg;
    localparam int BYTE_W  = 8;
    localparam int WORD_W  = 16;
    localparam int IDX_W   = 4;
    localparam int CNT_W   = 4;

    localparam logic [2:0]       DEV_ADDR_HI = 3'b010;
    localparam logic [IDX_W-1:0] IDX_RESULT  = 4'h0;
    localparam logic [IDX_W-1:0] IDX_ALARM   = 4'h1;
    localparam logic [IDX_W-1:0] IDX_TIMER   = 4'h3;
    localparam logic [BYTE_W-1:0] ALARM_WIPE = 8'hFF;

    typedef enum logic [2:0] {ST_IDLE, ST_ADDR, ST_WR, ST_HOLD, ST_RD} bus_st_t;
    typedef enum logic [1:0] {WP_PTR, WP_HI, WP_LO} wr_ph_t;

    typedef struct packed {
        logic rise;
        logic fall;
        logic start;
        logic stop;
    } line_ev_t;

    function automatic logic idx_is_wide(input logic [IDX_W-1:0] idx);
        return !(idx == IDX_ALARM || idx == IDX_TIMER);
    endfunction
endpackage

// File: rtl/cvt_i2c_linemon.sv
module cvt_i2c_linemon
    import cvt_i2c_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output line_ev_t ev
);
    logic scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    always_comb begin
        ev.rise  = scl_i & ~scl_q;
        ev.fall  = ~scl_i & scl_q;
        ev.start = scl_i & scl_q & sda_q & ~sda_i;
        ev.stop  = scl_i & scl_q & ~sda_q & sda_i;
    end
endmodule

// File: rtl/cvt_i2c_addrmatch.sv
module cvt_i2c_addrmatch
    import cvt_i2c_pkg::*;
#(
    parameter logic [3:0] LOW_PAT   = 4'h1,
    parameter logic [3:0] HIGH_PAT  = 4'h2,
    parameter logic [3:0] FLOAT_PAT = 4'h3
)(
    input  logic [1:0] addr_sel,
    input  logic [6:0] addr,
    output logic       hit
);
    localparam int N_LEVELS = 3;

    function automatic logic [3:0] pat_of(input int lvl);
        case (lvl)
            0:       return LOW_PAT;
            1:       return HIGH_PAT;
            default: return FLOAT_PAT;
        endcase
    endfunction

    logic [N_LEVELS-1:0] hits;

    for (genvar g = 0; g < N_LEVELS; g++) begin : g_lvl
        assign hits[g] = (addr_sel == 2'(g)) && (addr == {DEV_ADDR_HI, pat_of(g)});
    end

    assign hit = |hits;
endmodule

// File: rtl/cvt_i2c_ptr.sv
module cvt_i2c_ptr
    import cvt_i2c_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [BYTE_W-1:0] din,
    output logic [IDX_W-1:0]  idx,
    output logic              cmd_pulse,
    output logic [3:0]        cmd_code
);
    always_ff @(posedge clk) begin
        if (rst) begin
            idx       <= '0;
            cmd_pulse <= 1'b0;
            cmd_code  <= '0;
        end else begin
            cmd_pulse <= 1'b0;
            if (load) begin
                idx       <= din[IDX_W-1:0];
                cmd_code  <= din[BYTE_W-1:IDX_W];
                cmd_pulse <= (din[BYTE_W-1:IDX_W] != 4'h0);
            end
        end
    end

    // R4
    cmd_from_load_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_pulse |-> $past(load));
endmodule

// File: rtl/cvt_i2c_target.sv
module cvt_i2c_target
    import cvt_i2c_pkg::*;
#(
    parameter logic [3:0] LOW_PAT   = 4'h1,
    parameter logic [3:0] HIGH_PAT  = 4'h2,
    parameter logic [3:0] FLOAT_PAT = 4'h3
)(
    input  logic        clk,
    input  logic        rst,
    input  logic        scl_i,
    input  logic        sda_i,
    input  logic [1:0]  addr_sel,
    input  logic        conv_busy,
    input  logic [15:0] reg_rd_data,
    output logic        sda_low,
    output logic        scl_low,
    output logic [3:0]  reg_rd_idx,
    output logic        reg_rd,
    output logic        reg_wr,
    output logic [3:0]  reg_wr_idx,
    output logic [15:0] reg_wr_data,
    output logic        alarm_clr,
    output logic        cmd_pulse,
    output logic [3:0]  cmd_code
);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(BYTE_W + 1);

    line_ev_t          ev;
    bus_st_t           state;
    wr_ph_t            wph;
    logic [CNT_W-1:0]  bitcnt;
    logic [BYTE_W-1:0] shreg, obyte, tx_lo, hi_q, ptr_byte_q;
    logic              rw_q, nack_q, lo_next, ptr_load_q, hit;
    logic              sda_low_q, scl_low_q;
    logic [IDX_W-1:0]  ptr_idx;
    logic              wide_now;
    logic [BYTE_W-1:0] first_byte;

    cvt_i2c_linemon u_mon (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .ev(ev)
    );

    cvt_i2c_addrmatch #(
        .LOW_PAT(LOW_PAT), .HIGH_PAT(HIGH_PAT), .FLOAT_PAT(FLOAT_PAT)
    ) u_match (
        .addr_sel(addr_sel), .addr(shreg[7:1]), .hit(hit)
    );

    cvt_i2c_ptr u_ptr (
        .clk(clk), .rst(rst), .load(ptr_load_q), .din(ptr_byte_q),
        .idx(ptr_idx), .cmd_pulse(cmd_pulse), .cmd_code(cmd_code)
    );

    assign wide_now   = idx_is_wide(ptr_idx);
    assign first_byte = wide_now ? reg_rd_data[15:8] : reg_rd_data[7:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;  wph <= WP_PTR;  bitcnt <= '0;
            shreg <= '0;  obyte <= '0;  tx_lo <= '0;  hi_q <= '0;
            rw_q <= 1'b0;  nack_q <= 1'b0;  lo_next <= 1'b0;
            ptr_load_q <= 1'b0;  ptr_byte_q <= '0;
            sda_low_q <= 1'b0;  scl_low_q <= 1'b0;
            reg_rd <= 1'b0;  reg_wr <= 1'b0;  alarm_clr <= 1'b0;
            reg_wr_idx <= '0;  reg_wr_data <= '0;
        end else begin
            reg_rd <= 1'b0;  reg_wr <= 1'b0;  alarm_clr <= 1'b0;
            ptr_load_q <= 1'b0;
            if (ev.start) begin
                state <= ST_ADDR;  bitcnt <= '0;  wph <= WP_PTR;
                sda_low_q <= 1'b0;  scl_low_q <= 1'b0;
            end else if (ev.stop) begin
                state <= ST_IDLE;  bitcnt <= '0;  wph <= WP_PTR;
                sda_low_q <= 1'b0;  scl_low_q <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR: begin
                        if (ev.rise && bitcnt < LAST_BIT) begin
                            shreg  <= {shreg[6:0], sda_i};
                            bitcnt <= bitcnt + 1'b1;
                        end else if (ev.fall && bitcnt == LAST_BIT) begin
                            if (hit) begin
                                sda_low_q <= 1'b1;
                                rw_q      <= shreg[0];
                                bitcnt    <= ACK_SLOT;
                            end else begin
                                sda_low_q <= 1'b0;
                                state     <= ST_IDLE;
                            end
                        end else if (ev.fall && bitcnt == ACK_SLOT) begin
                            sda_low_q <= 1'b0;
                            bitcnt    <= '0;
                            if (!rw_q) begin
                                state <= ST_WR;
                                wph   <= WP_PTR;
                            end else if (conv_busy) begin
                                state     <= ST_HOLD;
                                scl_low_q <= 1'b1;
                            end else begin
                                state     <= ST_RD;
                                reg_rd    <= 1'b1;
                                tx_lo     <= reg_rd_data[7:0];
                                obyte     <= first_byte;
                                lo_next   <= wide_now;
                                sda_low_q <= ~first_byte[7];
                            end
                        end
                    end
                    ST_WR: begin
                        if (ev.rise && bitcnt < LAST_BIT) begin
                            shreg  <= {shreg[6:0], sda_i};
                            bitcnt <= bitcnt + 1'b1;
                        end else if (ev.fall && bitcnt == LAST_BIT) begin
                            sda_low_q <= 1'b1;
                            bitcnt    <= ACK_SLOT;
                            case (wph)
                                WP_PTR: begin
                                    ptr_load_q <= 1'b1;
                                    ptr_byte_q <= shreg;
                                    wph <= idx_is_wide(shreg[IDX_W-1:0]) ? WP_HI : WP_LO;
                                end
                                WP_HI: begin
                                    hi_q <= shreg;
                                    wph  <= WP_LO;
                                end
                                default: begin
                                    wph         <= WP_PTR;
                                    reg_wr_idx  <= ptr_idx;
                                    reg_wr_data <= wide_now ? {hi_q, shreg} : {8'h00, shreg};
                                    if (ptr_idx == IDX_ALARM && shreg == ALARM_WIPE)
                                        alarm_clr <= 1'b1;
                                    else if (ptr_idx != IDX_RESULT)
                                        reg_wr <= 1'b1;
                                end
                            endcase
                        end else if (ev.fall && bitcnt == ACK_SLOT) begin
                            sda_low_q <= 1'b0;
                            bitcnt    <= '0;
                        end
                    end
                    ST_HOLD: begin
                        if (!conv_busy) begin
                            scl_low_q <= 1'b0;
                            state     <= ST_RD;
                            bitcnt    <= '0;
                            reg_rd    <= 1'b1;
                            tx_lo     <= reg_rd_data[7:0];
                            obyte     <= first_byte;
                            lo_next   <= wide_now;
                            sda_low_q <= ~first_byte[7];
                        end
                    end
                    ST_RD: begin
                        if (ev.rise && bitcnt < LAST_BIT) begin
                            bitcnt <= bitcnt + 1'b1;
                        end else if (ev.rise && bitcnt == ACK_SLOT) begin
                            nack_q <= sda_i;
                        end else if (ev.fall && bitcnt != '0 && bitcnt < LAST_BIT) begin
                            sda_low_q <= ~obyte[3'(4'd7 - bitcnt)];
                        end else if (ev.fall && bitcnt == LAST_BIT) begin
                            sda_low_q <= 1'b0;
                            bitcnt    <= ACK_SLOT;
                        end else if (ev.fall && bitcnt == ACK_SLOT) begin
                            bitcnt <= '0;
                            if (nack_q) begin
                                state <= ST_IDLE;
                            end else if (lo_next) begin
                                obyte     <= tx_lo;
                                sda_low_q <= ~tx_lo[7];
                                lo_next   <= 1'b0;
                            end else begin
                                reg_rd    <= 1'b1;
                                tx_lo     <= reg_rd_data[7:0];
                                obyte     <= first_byte;
                                lo_next   <= wide_now;
                                sda_low_q <= ~first_byte[7];
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign sda_low    = sda_low_q;
    assign scl_low    = scl_low_q;
    assign reg_rd_idx = ptr_idx;

    // R10
    stretch_needs_busy_chk: assert property (@(posedge clk) disable iff (rst)
        scl_low_q |-> $past(conv_busy));
    // R11
    stop_release_chk: assert property (@(posedge clk) disable iff (rst)
        ev.stop |=> (!sda_low_q && !scl_low_q));
    // R8
    result_readonly_chk: assert property (@(posedge clk) disable iff (rst)
        reg_wr |-> (reg_wr_idx != IDX_RESULT));
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> !sda_low_q);
endmodule

// File: tb/cvt_i2c_target_bench.sv
module cvt_i2c_target_bench;
    localparam int Q = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic [1:0] addr_sel = 2'd0;
    logic conv_busy = 1'b0;
    logic [15:0] rf [16];
    logic scl_line, sda_line;
    logic [15:0] reg_rd_data;
    logic sda_low, scl_low, reg_rd, reg_wr, alarm_clr, cmd_pulse;
    logic [3:0] reg_rd_idx, reg_wr_idx, cmd_code;
    logic [15:0] reg_wr_data;

    int total = 0, bad = 0;
    logic [19:0] exp_wr[$];
    int exp_cmd[$];
    int exp_clr = 0;

    always #10 clk = ~clk;

    assign scl_line    = scl_m & ~scl_low;
    assign sda_line    = sda_m & ~sda_low;
    assign reg_rd_data = rf[reg_rd_idx];

    cvt_i2c_target u_cvt_i2c_target (
        .clk(clk), .rst(rst), .scl_i(scl_line), .sda_i(sda_line),
        .addr_sel(addr_sel), .conv_busy(conv_busy), .reg_rd_data(reg_rd_data),
        .sda_low(sda_low), .scl_low(scl_low), .reg_rd_idx(reg_rd_idx),
        .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_wr_idx(reg_wr_idx),
        .reg_wr_data(reg_wr_data), .alarm_clr(alarm_clr),
        .cmd_pulse(cmd_pulse), .cmd_code(cmd_code)
    );

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // reference model of the strobes, compared every clock
    always @(negedge clk) begin
        if (!rst) begin
            if (reg_wr) begin
                if (exp_wr.size() == 0) chk(1'b0, "R5 unexpected write", {reg_wr_idx, reg_wr_data}, 0);
                else begin
                    logic [19:0] e;
                    e = exp_wr.pop_front();
                    chk({reg_wr_idx, reg_wr_data} == e, "R5 write idx/data", {reg_wr_idx, reg_wr_data}, e);
                end
            end
            if (cmd_pulse) begin
                if (exp_cmd.size() == 0) chk(1'b0, "R4 unexpected command", cmd_code, 0);
                else begin
                    int c;
                    c = exp_cmd.pop_front();
                    chk(cmd_code == c[3:0], "R4 command code", cmd_code, c);
                end
            end
            if (alarm_clr) begin
                chk(exp_clr > 0, "R9 alarm clear", 1, exp_clr);
                if (exp_clr > 0) exp_clr--;
            end
        end
    end

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_bit(input logic b, output logic r);
        sda_m = b;
        hold(Q);
        scl_m = 1'b1;
        while (scl_line !== 1'b1) @(negedge clk);
        hold(Q);
        r = sda_line;
        hold(Q);
        scl_m = 1'b0;
        hold(Q);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; hold(Q);
        scl_m = 1'b1; hold(Q);
        sda_m = 1'b0; hold(Q);
        scl_m = 1'b0; hold(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; hold(Q);
        scl_m = 1'b1; hold(Q);
        sda_m = 1'b1; hold(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic r;
        for (int i = 7; i >= 0; i--) bus_bit(b[i], r);
        bus_bit(1'b1, r);
        ack = ~r;
    endtask

    task automatic recv_byte(output logic [7:0] b, input logic master_ack);
        logic r;
        for (int i = 7; i >= 0; i--) begin
            bus_bit(1'b1, r);
            b[i] = r;
        end
        bus_bit(~master_ack, r);
    endtask

    task automatic wbyte(input logic [7:0] b, input string req);
        logic a;
        send_byte(b, a);
        chk(a == 1'b1, req, a, 1);
    endtask

    task automatic expect_read(input logic [7:0] exp, input logic mack, input string req);
        logic [7:0] got;
        recv_byte(got, mack);
        chk(got == exp, req, got, exp);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog R1 actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic a;
        for (int i = 0; i < 16; i++) rf[i] = 16'(i * 16'h1357) ^ 16'hA5C3;
        hold(5);
        rst = 1'b0;
        hold(3);
        // R2 reset state
        chk(sda_low == 1'b0, "R2 sda released", sda_low, 0);
        chk(scl_low == 1'b0, "R2 scl released", scl_low, 0);
        chk(reg_rd_idx == 4'h0, "R2 pointer zero", reg_rd_idx, 0);

        // R1 wrong pattern for the low select is not acknowledged
        bus_start(); send_byte(8'h44, a); bus_stop();
        chk(a == 1'b0, "R1 mismatched address nack", a, 0);

        // R3 pointer-only write
        bus_start(); wbyte(8'h42, "R1 address ack"); wbyte(8'h05, "R3 pointer ack"); bus_stop();
        hold(4);
        chk(reg_rd_idx == 4'h5, "R3 pointer loaded", reg_rd_idx, 5);

        // R4 R5 R6 R8 R9 multi-register write
        exp_cmd.push_back(7);
        exp_wr.push_back({4'h2, 16'h1234});
        exp_wr.push_back({4'h3, 16'h005A});
        exp_clr = 1;
        exp_wr.push_back({4'h1, 16'h000F});
        bus_start(); wbyte(8'h42, "R1 address ack");
        wbyte(8'h72, "R4 pointer with command");
        wbyte(8'h12, "R5 high byte ack"); wbyte(8'h34, "R5 low byte ack");
        wbyte(8'h03, "R6 next pointer"); wbyte(8'h5A, "R5 single byte");
        wbyte(8'h01, "R6 next pointer"); wbyte(8'hFF, "R9 wipe byte");
        wbyte(8'h01, "R6 next pointer"); wbyte(8'h0F, "R9 normal alarm write");
        wbyte(8'h00, "R8 pointer result"); wbyte(8'hAB, "R8 data ack"); wbyte(8'hCD, "R8 data ack");
        bus_stop();
        hold(4);
        chk(exp_wr.size() == 0, "R6 all writes seen", exp_wr.size(), 0);
        chk(exp_cmd.size() == 0, "R4 command seen", exp_cmd.size(), 0);
        chk(exp_clr == 0, "R9 clear seen", exp_clr, 0);
        chk(reg_rd_idx == 4'h0, "R8 pointer on result, nothing written", reg_rd_idx, 0);

        // R11 partial 16-bit write discarded by STOP
        bus_start(); wbyte(8'h42, "R1 address ack"); wbyte(8'h04, "R11 pointer"); wbyte(8'h99, "R11 half");
        bus_stop();
        hold(4);
        chk(reg_rd_idx == 4'h4 && exp_wr.size() == 0, "R11 partial discarded", reg_rd_idx, 4);

        // R7 wide read with repeated START, R12 NACK end
        bus_start(); wbyte(8'h42, "R1 address ack"); wbyte(8'h06, "R7 pointer");
        bus_start(); wbyte(8'h43, "R11 repeated start read ack");
        chk(scl_low == 1'b0, "R10 no stretch when idle", scl_low, 0);
        expect_read(rf[6][15:8], 1'b1, "R7 upper byte");
        expect_read(rf[6][7:0],  1'b1, "R7 lower byte");
        expect_read(rf[6][15:8], 1'b0, "R7 wrap to upper");
        expect_read(8'hFF, 1'b0, "R12 released after nack");
        bus_stop();

        // R7 narrow read
        bus_start(); wbyte(8'h42, "R1 address ack"); wbyte(8'h03, "R7 pointer"); bus_stop();
        bus_start(); wbyte(8'h43, "R1 read address ack");
        expect_read(rf[3][7:0], 1'b1, "R7 narrow byte");
        expect_read(rf[3][7:0], 1'b0, "R7 narrow repeat");
        bus_stop();

        // R10 clock stretch on busy conversion
        bus_start(); wbyte(8'h42, "R1 address ack"); wbyte(8'h00, "R10 pointer"); bus_stop();
        conv_busy = 1'b1;
        bus_start(); wbyte(8'h43, "R10 read address ack");
        hold(4);
        chk(scl_low == 1'b1, "R10 stretch begins", scl_low, 1);
        hold(40);
        chk(scl_low == 1'b1 && scl_line == 1'b0, "R10 stretch held", scl_low, 1);
        conv_busy = 1'b0;
        hold(3);
        chk(scl_low == 1'b0, "R10 stretch released", scl_low, 0);
        expect_read(rf[0][15:8], 1'b1, "R10 upper after stretch");
        expect_read(rf[0][7:0],  1'b0, "R10 lower after stretch");
        bus_stop();

        // R1 other select levels
        addr_sel = 2'd1;
        bus_start(); send_byte(8'h44, a); bus_stop();
        chk(a == 1'b1, "R1 high select ack", a, 1);
        addr_sel = 2'd2;
        bus_start(); send_byte(8'h46, a); bus_stop();
        chk(a == 1'b1, "R1 float select ack", a, 1);
        addr_sel = 2'd3;
        bus_start(); send_byte(8'h42, a); bus_stop();
        chk(a == 1'b0, "R1 no-match select", a, 0);

        hold(10);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule